// File: doc/BRIEF.md
# Inbound Message Interrupt Status and Doorbell Block

This block collects the inbound message-unit events that concern the local processor and presents them as status bits. A mask register pairs with the status register, and a doorbell register is set from the host side. Each event input pulse sets its own status bit. Local software clears that bit by writing a one to it. Two further status bits summarise the doorbell register and are read-only. Local software clears them only by clearing the underlying bits in the doorbell register.

Every unmasked source drives one of two interrupt outputs. The doorbell machine-check summary drives the machine-check output. All other sources, including the doorbell interrupt summary, feed the regular interrupt output. The local register bus is a single-cycle write port with a combinational read port selected by a two-bit address. The host side sets doorbell bits through a write-one-to-set port.

Top module: `inbound_msg_irq`

## Requirements
- R1: After reset, the event status bits and the doorbell register read 0. Every implemented mask bit reads 1. Both interrupt outputs are 0.
- R2: A pulse on evtPulse[i] sets status bit i (address 0, bit i). The bit reads back 1 from the cycle after the pulse.
- R3: A write to address 0 clears each event status bit whose write-data bit is 1. Event status bits written with 0 keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bits NUM_EVT and NUM_EVT+1 at address 0 are read-only. A write to address 0 never changes them, whatever the data.
- R6: Status bit NUM_EVT reads as the OR of doorbell bits DB_W-2 down to 0. Status bit NUM_EVT+1 reads as doorbell bit DB_W-1, which is the doorbell machine-check bit.
- R7: A host doorbell write ORs hostDbData into the doorbell register (address 2). A local write to address 2 clears the bits written as 1. If both touch a bit in the same cycle, the bit ends up set.
- R8: The mask register (address 1) stores write-data bits NUM_EVT+1 down to 0. A mask bit of 1 suppresses its source. Read bits above the implemented width are 0 at every address.
- R9: intOut is 1 exactly when some status bit from NUM_EVT down to 0 is set while its mask bit is 0.
- R10: mcOut is 1 exactly when status bit NUM_EVT+1 is set while mask bit NUM_EVT+1 is 0.
- R11: Address 3 reads 0. A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Local register write strobe |
| regAddr | input | 2 | Register select: 0 status, 1 mask, 2 doorbell, 3 unused |
| regWrData | input | DATA_W | Local write data |
| regRdData | output | DATA_W | Combinational read data for regAddr |
| evtPulse | input | NUM_EVT | One-cycle event pulses, one per event status bit |
| hostDbWrEn | input | 1 | Host doorbell write strobe |
| hostDbData | input | DB_W | Doorbell bits to set |
| intOut | output | 1 | Regular interrupt request |
| mcOut | output | 1 | Machine-check request |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, an event pulse lands on the status bit being cleared. In the other, a host doorbell set meets a local doorbell clear on the same bit. In both, the set must win. The stimulus produces both collisions deliberately, and it also runs a long random phase in which pulses, host sets and local writes overlap freely. A behavioural model compares the read data and both outputs every cycle. This also exposes any read-only summary bit that a status write disturbs while doorbell bits are pending.

// File: rtl/inbound_msg_irq_pkg.sv
package inbound_msg_irq_pkg;

  typedef enum logic [1:0] {
    ADDR_STATUS   = 2'd0,
    ADDR_MASK     = 2'd1,
    ADDR_DOORBELL = 2'd2,
    ADDR_UNUSED   = 2'd3
  } regAddrE;

  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic wrDoorbell;
  } regStrobesT;

endpackage

// File: rtl/inbound_msg_irq_ctrl.sv
module inbound_msg_irq_ctrl
  import inbound_msg_irq_pkg::*;
(
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  output regStrobesT strobes
);

  regAddrE addrSel;

  always_comb begin
    addrSel            = regAddrE'(regAddr);
    strobes            = '0;
    strobes.wrStatus   = regWrEn && (addrSel == ADDR_STATUS);
    strobes.wrMask     = regWrEn && (addrSel == ADDR_MASK);
    strobes.wrDoorbell = regWrEn && (addrSel == ADDR_DOORBELL);
  end

endmodule

// File: rtl/inbound_msg_irq_dp.sv
module inbound_msg_irq_dp
  import inbound_msg_irq_pkg::*;
#(
  parameter int NUM_EVT = 6,
  parameter int DB_W    = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobesT         strobes,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic               hostDbWrEn,
  input  logic [DB_W-1:0]    hostDbData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               intOut,
  output logic               mcOut,
  output logic [NUM_EVT-1:0] evtQ,
  output logic [DB_W-1:0]    dbQ,
  output logic [NUM_EVT+1:0] maskQ
);

  localparam int STAT_W = NUM_EVT + 2;
  localparam int MC_BIT = STAT_W - 1;

  logic [NUM_EVT-1:0] evtNext;
  logic [DB_W-1:0]    dbNext;
  logic [STAT_W-1:0]  statusView;

  // Per-bit event status: a set always beats a same-cycle clear.
  for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
    assign evtNext[gi] = evtPulse[gi] |
                         (evtQ[gi] & ~(strobes.wrStatus & regWrData[gi]));
  end

  always_comb begin
    dbNext = dbQ;
    if (strobes.wrDoorbell) dbNext = dbNext & ~regWrData[DB_W-1:0];
    if (hostDbWrEn)         dbNext = dbNext | hostDbData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtQ  <= '0;
      dbQ   <= '0;
      maskQ <= '1;
    end else begin
      evtQ <= evtNext;
      dbQ  <= dbNext;
      if (strobes.wrMask) maskQ <= regWrData[STAT_W-1:0];
    end
  end

  assign statusView = {dbQ[DB_W-1], |dbQ[DB_W-2:0], evtQ};

  assign intOut = |(statusView[MC_BIT-1:0] & ~maskQ[MC_BIT-1:0]);
  assign mcOut  = statusView[MC_BIT] & ~maskQ[MC_BIT];

  always_comb begin
    regRdData = '0;
    unique case (regAddrE'(regAddr))
      ADDR_STATUS:   regRdData[STAT_W-1:0] = statusView;
      ADDR_MASK:     regRdData[STAT_W-1:0] = maskQ;
      ADDR_DOORBELL: regRdData[DB_W-1:0]   = dbQ;
      default:       regRdData = '0;
    endcase
  end

endmodule

// File: rtl/inbound_msg_irq.sv
module inbound_msg_irq
  import inbound_msg_irq_pkg::*;
#(
  parameter int NUM_EVT = 6,
  parameter int DB_W    = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic               hostDbWrEn,
  input  logic [DB_W-1:0]    hostDbData,
  output logic               intOut,
  output logic               mcOut
);

  regStrobesT         strobes;
  logic [NUM_EVT-1:0] evtQ;
  logic [DB_W-1:0]    dbQ;
  logic [NUM_EVT+1:0] maskQ;

  inbound_msg_irq_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  inbound_msg_irq_dp #(
    .NUM_EVT (NUM_EVT),
    .DB_W    (DB_W),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .evtPulse   (evtPulse),
    .hostDbWrEn (hostDbWrEn),
    .hostDbData (hostDbData),
    .regRdData  (regRdData),
    .intOut     (intOut),
    .mcOut      (mcOut),
    .evtQ       (evtQ),
    .dbQ        (dbQ),
    .maskQ      (maskQ)
  );

endmodule

// File: rtl/inbound_msg_irq_chk.sv
module inbound_msg_irq_chk #(
  parameter int NUM_EVT = 6,
  parameter int DB_W    = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [1:0]         regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic [NUM_EVT-1:0] evtPulse,
  input logic               hostDbWrEn,
  input logic [DB_W-1:0]    hostDbData,
  input logic               intOut,
  input logic               mcOut,
  input logic [NUM_EVT-1:0] evtQ,
  input logic [DB_W-1:0]    dbQ,
  input logic [NUM_EVT+1:0] maskQ
);

  // R1
  mask_reset_chk: assert property (@(posedge clk)
    !rstN |=> (&maskQ && evtQ == '0 && dbQ == '0));

  // R2
  evt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((evtQ & $past(evtPulse)) == $past(evtPulse)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0) |=>
      ((evtQ & $past(regWrData[NUM_EVT-1:0] & ~evtPulse)) == '0));

  // R5
  ro_summary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0 && !hostDbWrEn) |=> $stable(dbQ));

  // R7
  host_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostDbWrEn |=> ((dbQ & $past(hostDbData)) == $past(hostDbData)));

  // R9
  int_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ[NUM_EVT:0]) |-> !intOut);

  // R10
  mc_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[NUM_EVT+1] || !dbQ[DB_W-1]) |-> !mcOut);

  // R11
  unused_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd3 && !hostDbWrEn && evtPulse == '0) |=>
      ($stable(dbQ) && $stable(maskQ) && $stable(evtQ)));

endmodule

bind inbound_msg_irq inbound_msg_irq_chk #(
  .NUM_EVT (NUM_EVT),
  .DB_W    (DB_W),
  .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/inbound_msg_irq_tb.sv
module inbound_msg_irq_tb;

  localparam int NE = 6;
  localparam int DB = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          regWrEn;
  logic [1:0]    regAddr;
  logic [DW-1:0] regWrData;
  logic [DW-1:0] regRdData;
  logic [NE-1:0] evtPulse;
  logic          hostDbWrEn;
  logic [DB-1:0] hostDbData;
  logic          intOut;
  logic          mcOut;

  int    nChecks = 0;
  int    nFails  = 0;
  string phase   = "R1";
  bit    started = 0;
  bit    done    = 0;

  // behavioural reference state
  logic [NE-1:0] mEvt;
  logic [DB-1:0] mDb;
  logic [NE+1:0] mMask;

  always #10 clk = ~clk;

  inbound_msg_irq #(.NUM_EVT(NE), .DB_W(DB), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse),
    .hostDbWrEn(hostDbWrEn), .hostDbData(hostDbData),
    .intOut(intOut), .mcOut(mcOut)
  );

  function automatic logic [DW-1:0] expRead(input logic [1:0] a);
    logic [DW-1:0] r = '0;
    if (a == 2'd0) r[NE+1:0] = {mDb[DB-1], |mDb[DB-2:0], mEvt};
    else if (a == 2'd1) r[NE+1:0] = mMask;
    else if (a == 2'd2) r[DB-1:0] = mDb;
    return r;
  endfunction

  task automatic chk(input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  // reference model update
  always @(posedge clk) begin
    started <= 1'b1;
    if (!rstN) begin
      mEvt  <= '0;
      mDb   <= '0;
      mMask <= '1;
    end else begin
      logic [NE-1:0] e;
      logic [DB-1:0] d;
      e = mEvt;
      d = mDb;
      if (regWrEn && regAddr == 2'd0) e = e & ~regWrData[NE-1:0];
      e = e | evtPulse;
      if (regWrEn && regAddr == 2'd2) d = d & ~regWrData[DB-1:0];
      if (hostDbWrEn) d = d | hostDbData;
      mEvt <= e;
      mDb  <= d;
      if (regWrEn && regAddr == 2'd1) mMask <= regWrData[NE+1:0];
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("regRdData", regRdData, expRead(regAddr));
      chk("intOut (R9)", {31'b0, intOut},
          {31'b0, |({|mDb[DB-2:0], mEvt} & ~mMask[NE:0])});
      chk("mcOut (R10)", {31'b0, mcOut},
          {31'b0, mDb[DB-1] & ~mMask[NE+1]});
    end
  end

  task automatic cyc(input logic wr, input logic [1:0] a, input logic [DW-1:0] d,
                     input logic [NE-1:0] ev, input logic hw, input logic [DB-1:0] hd);
    @(posedge clk);
    #5;
    regWrEn = wr; regAddr = a; regWrData = d;
    evtPulse = ev; hostDbWrEn = hw; hostDbData = hd;
  endtask

  task automatic rd(input logic [1:0] a);
    cyc(1'b0, a, '0, '0, 1'b0, '0);
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; regWrEn = 0; regAddr = 0; regWrData = '0;
    evtPulse = '0; hostDbWrEn = 0; hostDbData = '0;
    phase = "R1";
    for (int i = 0; i < 4; i++) cyc(1'b0, 2'(i), '0, '0, 1'b0, '0);
    cyc(1'b0, 2'd1, '0, '0, 1'b0, '0);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) rd(2'(i));
    phase = "R8";
    cyc(1'b1, 2'd1, 32'hFFFF_FF00, '0, 1'b0, '0);
    rd(2'd1);
    cyc(1'b1, 2'd1, 32'hFFFF_FFFF, '0, 1'b0, '0);
    rd(2'd1);
    phase = "R2";
    for (int i = 0; i < NE; i++) cyc(1'b0, 2'd0, '0, NE'(1 << i), 1'b0, '0);
    rd(2'd0);
    phase = "R3";
    cyc(1'b1, 2'd0, 32'h0000_0005, '0, 1'b0, '0);
    rd(2'd0);
    cyc(1'b1, 2'd0, 32'h0, '0, 1'b0, '0);
    rd(2'd0);
    phase = "R4";
    cyc(1'b1, 2'd0, 32'h0000_003F, 6'b00_0010, 1'b0, '0);
    rd(2'd0);
    phase = "R7";
    cyc(1'b0, 2'd2, '0, '0, 1'b1, 8'h81);
    rd(2'd2);
    cyc(1'b1, 2'd2, 32'h0000_0001, '0, 1'b1, 8'h01);
    rd(2'd2);
    phase = "R6";
    rd(2'd0);
    phase = "R5";
    cyc(1'b1, 2'd0, 32'hFFFF_FFFF, '0, 1'b0, '0);
    rd(2'd0);
    rd(2'd2);
    phase = "R9";
    cyc(1'b1, 2'd1, 32'h0000_00BF, '0, 1'b0, '0);
    rd(2'd0);
    cyc(1'b1, 2'd2, 32'h0000_007F, '0, 1'b0, '0);
    rd(2'd0);
    phase = "R10";
    cyc(1'b1, 2'd1, 32'h0000_007F, '0, 1'b0, '0);
    rd(2'd0);
    cyc(1'b1, 2'd2, 32'h0000_0080, '0, 1'b0, '0);
    rd(2'd0);
    phase = "R11";
    cyc(1'b0, 2'd2, '0, '0, 1'b1, 8'h42);
    cyc(1'b1, 2'd3, 32'hFFFF_FFFF, '0, 1'b0, '0);
    for (int i = 0; i < 4; i++) rd(2'(i));
    phase = "mixed";
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r0 = $urandom;
      logic [31:0] r1 = $urandom;
      cyc(r0[0] & r0[1], r0[3:2], r1, NE'(r0[9:4] & r0[15:10]),
          r0[16] & r0[17], r0[25:18] & r1[7:0]);
    end
    rd(2'd0);
    finishRun();
  end

endmodule